// File: doc/BRIEF.md
# Transient Injection Multiplexer Bank

This block sits between a set of chosen logic nodes and the logic that reads them. For each node, an injector either forwards the node's true value or overlays a transient pulse from an external pulse source. The overlay takes one of two forms. A dip forces the node low for as long as the pulse is high, which models a strike on the pull-down side. A spike forces the node high for as long as the pulse is high, which models a strike on the pull-up side.

A shared arm input allows injection only during the test windows chosen by the test controller. Each injector has its own two-bit mode and its own pulse input. Several nodes can therefore be disturbed in the same clock cycle, which emulates charge shared across neighbouring nodes.

Each injector also reports whether its overlay actually changed the node's logic level. An overlay that drives the level the node already has is logically masked. A per-injector saturating counter totals the clock cycles in which the overlay was effective. These totals can be compared against the errors observed downstream, and each counter can be cleared on its own.

Top module: `tinj_bank`

## Requirements
- R1: With mode 00 (pass), `node_out[i]` equals `node_in[i]` whatever `pulse_in[i]` and `arm` are.
- R2: With mode 01 (dip), `arm` high and `pulse_in[i]` high, `node_out[i]` is 0 in that same cycle. In every other case for this mode, `node_out[i]` follows `node_in[i]`.
- R3: With mode 10 (spike), `arm` high and `pulse_in[i]` high, `node_out[i]` is 1 in that same cycle. In every other case for this mode, `node_out[i]` follows `node_in[i]`.
- R4: Mode 11 is reserved. In this mode the injector acts as pass, and `bad_mode[i]` is 1. In modes 00, 01 and 10, `bad_mode[i]` is 0.
- R5: While `arm` is 0, no injector alters its node, in any mode and with any pulse.
- R6: `eff_hit[i]` is 1 exactly when an overlay is active and the forced level differs from `node_in[i]`. For example, a spike on a node that is already 1 gives `eff_hit[i]` = 0.
- R7: Injectors are independent. Any subset of them can overlay in the same cycle, each according to its own mode, node and pulse.
- R8: At each rising clock edge where `eff_hit[i]` is 1 and no clear is requested, counter i increases by one. The counter holds at its all-ones value. Counter i is read from `hit_cnt[i*CNT_W +: CNT_W]`.
- R9: When `cnt_clr[i]` is 1 at a rising edge, counter i becomes 0 at that edge. This takes priority over a simultaneous effective hit.
- R10: While `rst_n` is low at a rising edge, every counter becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hit counters |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Global permission to inject |
| node_in | input | N_NODES | True values of the chosen nodes |
| pulse_in | input | N_NODES | Transient pulse per injector, high while the transient lasts |
| mode_sel | input | 2*N_NODES | Mode per injector; bits 2i+1:2i belong to injector i |
| cnt_clr | input | N_NODES | Clear request per counter |
| node_out | output | N_NODES | Node values driven onward |
| eff_hit | output | N_NODES | Overlay changed the node level in this cycle |
| bad_mode | output | N_NODES | Reserved mode selected |
| hit_cnt | output | N_NODES*CNT_W | Effective-hit cycle counts, packed per injector |

## Verification
The bench builds the bank with N_NODES = 3 and CNT_W = 4. Three injectors are enough to fire two overlays and a masked one in the same cycle. A 4-bit counter reaches its all-ones value after 15 effective cycles, so the bench can drive saturation and a clear that coincides with a hit within a few dozen cycles. The sweep applies every mode, with both node levels and with arm high and low, to injector 0. Each pulse lasts two cycles, so the output and the effective flag are checked on every cycle of the pulse.

// File: rtl/tinj_pkg.sv
// Package tinj_pkg
// Shared mode encoding for the transient injectors.
// Assumes a two-bit mode field per injector.
package tinj_pkg;
    typedef enum logic [1:0] {
        MODE_PASS = 2'b00,
        MODE_DIP  = 2'b01,
        MODE_SPK  = 2'b10,
        MODE_RSVD = 2'b11
    } inj_mode_e;
endpackage

// File: rtl/tinj_cell.sv
// Module tinj_cell
// Purely combinational overlay for one node. Decodes the mode, forces the
// node low (dip) or high (spike) while armed and pulsed, and reports whether
// the forced level differs from the true value.
// Assumes pulse is already aligned to the wanted moment by the pulse source.
module tinj_cell
    import tinj_pkg::*;
(
    input  logic       node_val,
    input  logic       pulse,
    input  logic       arm,
    input  logic [1:0] mode_bits,
    output logic       drive_val,
    output logic       eff,
    output logic       bad
);
    inj_mode_e mode;
    logic      active;
    logic      forced;

    // Decode the mode into overlay enable and forced level
    always_comb begin
        mode   = inj_mode_e'(mode_bits);
        active = 1'b0;
        forced = 1'b0;
        bad    = 1'b0;
        case (mode)
            MODE_DIP: begin
                active = arm & pulse;
                forced = 1'b0;
            end
            MODE_SPK: begin
                active = arm & pulse;
                forced = 1'b1;
            end
            MODE_RSVD: bad = 1'b1;
            default: active = 1'b0;
        endcase
    end

    // Select the forwarded level and flag a level change
    always_comb begin
        drive_val = active ? forced : node_val;
        eff       = active & (forced != node_val);
    end
endmodule

// File: rtl/tinj_hitcnt.sv
// Module tinj_hitcnt
// Saturating counter of effective-hit cycles for one injector.
// Clear has priority over increment; synchronous active-low reset.
module tinj_hitcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count effective cycles, clearing or holding at the top
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (hit && count != CNT_MAX)
            count <= count + 1'b1;
    end

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && hit && count != CNT_MAX) |=> count == CNT_W'($past(count) + 1'b1));
    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count == CNT_MAX) |=> count == CNT_MAX);
    // R9
    cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    // R8
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hit) |=> $stable(count));
endmodule

// File: rtl/tinj_bank.sv
// Module tinj_bank
// Bank of N_NODES transient injectors sharing one arm input. Each injector
// has its own mode, pulse, effective-hit flag and saturating counter.
// Assumes node_in and pulse_in are settled before the edge that counts them.
module tinj_bank
    import tinj_pkg::*;
#(
    parameter int N_NODES = 4,
    parameter int CNT_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       arm,
    input  logic [N_NODES-1:0]         node_in,
    input  logic [N_NODES-1:0]         pulse_in,
    input  logic [2*N_NODES-1:0]       mode_sel,
    input  logic [N_NODES-1:0]         cnt_clr,
    output logic [N_NODES-1:0]         node_out,
    output logic [N_NODES-1:0]         eff_hit,
    output logic [N_NODES-1:0]         bad_mode,
    output logic [N_NODES*CNT_W-1:0]   hit_cnt
);
    localparam int MODE_W = 2;

    for (genvar gi = 0; gi < N_NODES; gi++) begin : g_inj
        logic [MODE_W-1:0] md;
        assign md = mode_sel[gi*MODE_W +: MODE_W];

        tinj_cell u_cell (
            .node_val  (node_in[gi]),
            .pulse     (pulse_in[gi]),
            .arm       (arm),
            .mode_bits (md),
            .drive_val (node_out[gi]),
            .eff       (eff_hit[gi]),
            .bad       (bad_mode[gi])
        );

        tinj_hitcnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr[gi]),
            .hit   (eff_hit[gi]),
            .count (hit_cnt[gi*CNT_W +: CNT_W])
        );

        // R1
        pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (md == MODE_PASS) |-> node_out[gi] == node_in[gi]);
        // R2
        dip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (arm && pulse_in[gi] && md == MODE_DIP) |-> !node_out[gi]);
        // R3
        spike_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (arm && pulse_in[gi] && md == MODE_SPK) |-> node_out[gi]);
        // R4
        rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (md == MODE_RSVD) |-> (bad_mode[gi] && node_out[gi] == node_in[gi]));
        // R5
        disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !arm |-> (node_out[gi] == node_in[gi] && !eff_hit[gi]));
        // R6
        eff_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
            eff_hit[gi] |-> node_out[gi] != node_in[gi]);
    end
endmodule

// File: tb/tinj_bank_tb_top.sv
`timescale 1ns/1ps
module tinj_bank_tb_top;
    localparam int N  = 3;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic [N-1:0] node_in = '0, pulse_in = '0, cnt_clr = '0;
    logic [2*N-1:0] mode_sel = '0;
    logic [N-1:0] node_out, eff_hit, bad_mode;
    logic [N*CW-1:0] hit_cnt;

    typedef struct {
        logic [N-1:0]    o;
        logic [N-1:0]    e;
        logic [N-1:0]    b;
        logic [N*CW-1:0] c;
        string           tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_bad = 0;
    int mcnt[N];
    bit done = 0;

    always #2.5 clk = ~clk;

    tinj_bank #(.N_NODES(N), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .node_in(node_in),
        .pulse_in(pulse_in), .mode_sel(mode_sel), .cnt_clr(cnt_clr),
        .node_out(node_out), .eff_hit(eff_hit), .bad_mode(bad_mode),
        .hit_cnt(hit_cnt)
    );

    // Driver: apply inputs at negedge, push expectation, then advance the counter model
    task automatic apply(input logic a, input logic [N-1:0] nd, input logic [N-1:0] pl,
                         input logic [2*N-1:0] md, input logic [N-1:0] clr, input string tag);
        exp_t it;
        @(negedge clk);
        arm = a; node_in = nd; pulse_in = pl; mode_sel = md; cnt_clr = clr;
        #1;
        for (int i = 0; i < N; i++) begin
            logic [1:0] m;
            logic act, frc;
            m   = md[2*i +: 2];
            act = a && pl[i] && (m == 2'b01 || m == 2'b10);
            frc = (m == 2'b10);
            it.o[i] = act ? frc : nd[i];
            it.e[i] = act && (frc != nd[i]);
            it.b[i] = (m == 2'b11);
            it.c[i*CW +: CW] = CW'(mcnt[i]);
        end
        it.tag = tag;
        q.push_back(it);
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (!rst_n || clr[i]) mcnt[i] = 0;
            else if (it.e[i] && mcnt[i] != CMAX) mcnt[i]++;
        end
    endtask

    // Monitor: pop expectations and compare with the outputs
    initial begin
        forever begin
            exp_t it;
            wait (q.size() > 0);
            it = q.pop_front();
            n_chk++;
            if (node_out !== it.o) begin
                n_bad++;
                $display("FAIL %s node_out act=%b exp=%b", it.tag, node_out, it.o);
            end
            n_chk++;
            if (eff_hit !== it.e) begin
                n_bad++;
                $display("FAIL %s/R6 eff_hit act=%b exp=%b", it.tag, eff_hit, it.e);
            end
            n_chk++;
            if (bad_mode !== it.b) begin
                n_bad++;
                $display("FAIL %s/R4 bad_mode act=%b exp=%b", it.tag, bad_mode, it.b);
            end
            n_chk++;
            if (hit_cnt !== it.c) begin
                n_bad++;
                $display("FAIL %s/R8 hit_cnt act=%h exp=%h", it.tag, hit_cnt, it.c);
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Stimulus
    initial begin
        for (int i = 0; i < N; i++) mcnt[i] = 0;
        rst_n = 1'b0;
        // R10: counters held at zero through reset
        repeat (3) apply(1'b0, '0, '0, '0, '0, "R10");
        rst_n = 1'b1;
        apply(1'b0, '0, '0, '0, '0, "R10");

        // Sweep injector 0 over modes, node levels and arm; pulse lasts two cycles
        for (int m = 0; m < 4; m++) begin
            for (int nd = 0; nd < 2; nd++) begin
                for (int a = 0; a < 2; a++) begin
                    string tg;
                    logic [2*N-1:0] md;
                    tg = (a == 0) ? "R5" : (m == 0) ? "R1" : (m == 1) ? "R2" :
                         (m == 2) ? "R3" : "R4";
                    md = {4'b0000, 2'(m)};
                    apply(1'(a), {2'b10, 1'(nd)}, 3'b111, md, '0, tg);
                    apply(1'(a), {2'b01, 1'(nd)}, 3'b111, md, '0, tg);
                    apply(1'(a), {2'b10, 1'(nd)}, 3'b000, md, '0, tg);
                end
            end
        end

        // R7: two effective overlays and one masked overlay in the same cycle
        repeat (3) apply(1'b1, 3'b001, 3'b111, {2'b01, 2'b10, 2'b01}, '0, "R7");
        apply(1'b1, 3'b001, 3'b000, {2'b01, 2'b10, 2'b01}, '0, "R7");

        // R9: clear all counters
        apply(1'b1, '0, '0, '0, 3'b111, "R9");
        // R8: saturation on injector 1 (spike on low node)
        repeat (18) apply(1'b1, 3'b000, 3'b010, {2'b00, 2'b10, 2'b00}, '0, "R8");
        // R9: clear coincident with an effective hit wins
        apply(1'b1, 3'b000, 3'b010, {2'b00, 2'b10, 2'b00}, 3'b010, "R9");
        apply(1'b1, 3'b000, 3'b010, {2'b00, 2'b10, 2'b00}, '0, "R9");
        apply(1'b0, 3'b000, 3'b000, '0, '0, "R9");

        wait (q.size() == 0);
        #1;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule